// File: doc/BRIEF.md
# Signed Nibble Seven-Segment Decoder

This block turns a 4-bit two's complement value into a pair of seven-segment display patterns. The right-hand display shows the size of the value as a single decimal digit. The left-hand display only indicates the sign: it lights a minus bar for negative inputs and stays dark otherwise.

The signed range of the input is -8 to +7. The magnitude digit therefore has to cover 0 to 8, and 8 appears only for the most negative code. The block is purely combinational and has no clock or reset. A board or a larger datapath drives the nibble, and the two segment buses go straight to the display drivers.

Top module: `snd_signed_nibble_display`

## Requirements
- R1: Segment bit 6 (g, the middle bar) of the sign display is 1 exactly when input bit 3 (the sign bit) is 1.
- R2: Sign display segment bits 5..0 (f..a) are 0 for every input value.
- R3: When input bit 3 is 0, the magnitude display shows the input's value, from 0 to 7.
- R4: When input bit 3 is 1, the magnitude display shows 16 minus the input's unsigned value, which is the two's complement negation, from 1 to 8.
- R5: Input 1000 shows the digit 8 (all seven magnitude segments lit) together with the minus bar.
- R6: Segment buses are active high with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. The digits use the usual shapes: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = abcdefg.
- R7: Input 0011 shows the digit 3 with the sign display fully dark.
- R8: Input 1111 shows the minus bar and the digit 1.
- R9: Both outputs follow a change of the input with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| nib_in | input | 4 | Two's complement value, bit 3 is the sign |
| mag_seg | output | 7 | Magnitude digit segments, bit 0 = a through bit 6 = g, active high |
| sign_seg | output | 7 | Sign display segments, only bit 6 (g) can be lit |

## Verification
The hardest case to reach is input 1000. It is the only code whose negation does not fit the positive range, so it is the only one that shows the digit 8. A decoder that computes the negation in too few bits, or treats the magnitude as signed, gets every other code right. The stimulus walks all sixteen codes, then checks 1000, 0011 and 1111 directly, and then applies seeded random codes between those checks. That random order also exercises transitions into and out of the most negative value with no clock edge.

// File: rtl/snd_pkg.sv
package snd_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    localparam int MAG_W = NIB_W;
    localparam int SEG_G = 6;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } sgn_mag_t;

    localparam seg_t SEG_BLANK = '0;
    localparam seg_t SEG_MINUS = seg_t'(1) << SEG_G;

    // digit to segment pattern, bit 0 = a ... bit 6 = g
    function automatic seg_t digit_pattern(input logic [MAG_W-1:0] d);
        seg_t s;
        case (d)
            4'd0:    s = 7'b0111111;
            4'd1:    s = 7'b0000110;
            4'd2:    s = 7'b1011011;
            4'd3:    s = 7'b1001111;
            4'd4:    s = 7'b1100110;
            4'd5:    s = 7'b1101101;
            4'd6:    s = 7'b1111101;
            4'd7:    s = 7'b0000111;
            4'd8:    s = 7'b1111111;
            default: s = SEG_BLANK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/snd_sign_split.sv
module snd_sign_split
    import snd_pkg::*;
(
    input  nib_t     nib,
    output sgn_mag_t sm
);
    logic [MAG_W-1:0] negated;

    always_comb begin
        negated = (~nib) + MAG_W'(1);
        sm.neg  = nib[NIB_W-1];
        sm.mag  = sm.neg ? negated : nib;
    end

    always_comb begin
        // R3 R4: magnitude never exceeds 8
        p_mag_range_r4: assert (sm.mag <= MAG_W'(8));
        // R5: only the most negative code yields 8
        p_min_gives_eight_r5: assert ((sm.mag == MAG_W'(8)) == (nib == 4'b1000));
    end
endmodule

// File: rtl/snd_digit_enc.sv
module snd_digit_enc
    import snd_pkg::*;
(
    input  logic [MAG_W-1:0] digit,
    output seg_t             seg
);
    always_comb seg = digit_pattern(digit);

    always_comb begin
        // R6: digit 1 lights exactly two segments
        p_one_two_segs_r6: assert ((digit != MAG_W'(1)) || ($countones(seg) == 2));
        // R6: digits 0..8 never produce a dark display
        p_digit_visible_r6: assert ((digit > MAG_W'(8)) || (seg != SEG_BLANK));
    end
endmodule

// File: rtl/snd_sign_enc.sv
module snd_sign_enc
    import snd_pkg::*;
(
    input  logic neg,
    output seg_t seg
);
    always_comb seg = neg ? SEG_MINUS : SEG_BLANK;

    always_comb begin
        // R2: never more than one sign segment lit
        p_sign_single_r2: assert ($onehot0(seg));
    end
endmodule

// File: rtl/snd_signed_nibble_display.sv
module snd_signed_nibble_display
    import snd_pkg::*;
(
    input  logic [3:0] nib_in,
    output logic [6:0] mag_seg,
    output logic [6:0] sign_seg
);
    sgn_mag_t sm;
    seg_t     mag_s;
    seg_t     sign_s;

    snd_sign_split u_split (
        .nib (nib_in),
        .sm  (sm)
    );

    snd_digit_enc u_digit (
        .digit (sm.mag),
        .seg   (mag_s)
    );

    snd_sign_enc u_sign (
        .neg (sm.neg),
        .seg (sign_s)
    );

    assign mag_seg  = mag_s;
    assign sign_seg = sign_s;

    always_comb begin
        // R1: minus bar tracks the input sign bit
        p_minus_tracks_msb_r1: assert (sign_seg[SEG_G] == nib_in[NIB_W-1]);
        // R2: sign display segments a..f stay dark
        p_sign_af_dark_r2: assert (sign_seg[SEG_G-1:0] == '0);
        // R7: 0011 shows 3 with blank sign
        p_three_plain_r7: assert ((nib_in != 4'b0011) || (mag_seg == 7'b1001111 && sign_seg == '0));
    end
endmodule

// File: tb/snd_signed_nibble_display_bench.sv
module snd_signed_nibble_display_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 10000;

    logic       clk = 1'b0;
    logic [3:0] nib_in = 4'd0;
    logic [6:0] mag_seg;
    logic [6:0] sign_seg;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    bit         done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_signed_nibble_display u_snd_signed_nibble_display (
        .nib_in   (nib_in),
        .mag_seg  (mag_seg),
        .sign_seg (sign_seg)
    );

    // per-segment rule: which digits light each segment (bit0=a .. bit6=g)
    function automatic logic [6:0] want_digit(input int d);
        logic [6:0] s;
        s[0] = !(d == 1 || d == 4);
        s[1] = !(d == 5 || d == 6);
        s[2] = (d != 2);
        s[3] = !(d == 1 || d == 4 || d == 7);
        s[4] = (d == 0 || d == 2 || d == 6 || d == 8);
        s[5] = !(d == 1 || d == 2 || d == 3 || d == 7);
        s[6] = !(d == 0 || d == 1 || d == 7);
        return s;
    endfunction

    function automatic int want_mag(input logic [3:0] v);
        int sv;
        sv = (v >= 8) ? int'(v) - 16 : int'(v);
        return (sv < 0) ? -sv : sv;
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s nib=%b actual=%b expected=%b", req, nib_in, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [3:0] v);
        @(negedge clk);
        nib_in = v;
        #1;
        // R9: outputs settle with no clock edge in between
        check(v[3] ? "R4" : "R3", mag_seg, want_digit(want_mag(v)));
        check("R1", {6'd0, sign_seg[6]}, {6'd0, v[3]});
        check("R2", {1'b0, sign_seg[5:0]}, 7'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2417));
        #1;
        // reset-like initial state: input zero shows 0, blank sign
        check("R3", mag_seg, 7'b0111111);
        check("R2", sign_seg, 7'd0);

        // R6: exhaustive walk of all codes
        for (int i = 0; i < 16; i++) apply_and_check(4'(i));

        // R6: explicit digit shapes through positive codes
        apply_and_check(4'd1);
        check("R6", mag_seg, 7'b0000110);
        apply_and_check(4'd4);
        check("R6", mag_seg, 7'b1100110);

        // R5: most negative value
        apply_and_check(4'b1000);
        check("R5", mag_seg, 7'b1111111);
        check("R5", sign_seg, 7'b1000000);

        // R7
        apply_and_check(4'b0011);
        check("R7", mag_seg, 7'b1001111);
        check("R7", sign_seg, 7'd0);

        // R8
        apply_and_check(4'b1111);
        check("R8", mag_seg, 7'b0000110);
        check("R8", sign_seg, 7'b1000000);

        // R9: change input mid-cycle, check without any edge
        @(posedge clk);
        #2;
        nib_in = 4'b1000;
        #1;
        check("R9", mag_seg, 7'b1111111);
        nib_in = 4'b0111;
        #1;
        check("R9", mag_seg, 7'b0000111);

        // random codes interleaved with the most negative value
        for (int k = 0; k < 200; k++) begin
            apply_and_check(4'($urandom % 16));
            if (k % 25 == 0) apply_and_check(4'b1000);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule